// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block moves a processor core from ordinary execution into an exception handler. Each cycle it samples seven requests: a core reset request, a data abort, a fast interrupt, a normal interrupt, a prefetch abort, an undefined-instruction strobe and a software-interrupt strobe. It also samples the current program counter and status word. If at least one request is live and not masked, exactly one of them wins by fixed priority. On the next clock edge the block presents five results:
- the handler target address;
- the status word for the mode being entered;
- the value to write into that mode's banked link register;
- the value to write into its banked saved-status register;
- a one-cycle redirect pulse for the fetch unit.

The status word has fixed fields that the rest of the core decodes. Bits [4:0] hold the mode code. Bit 5 is the compact-instruction-set (T) flag. Bit 6 is the fast-interrupt disable (F). Bit 7 is the normal-interrupt disable (I). The register file, the pipeline and the return path are outside this block. For a synchronous exception (software interrupt, undefined instruction or an abort), the program counter input must carry the address of the faulting instruction. For an interrupt or a reset, it carries the current program counter.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, redirect_o is 0 and target_o, status_o, link_o and saved_o are all zero, whatever the request inputs are doing.
- R2: A request that is sampled on a clock edge produces its results and a redirect_o pulse after that edge, and the pulse lasts one cycle. If no exception is taken, redirect_o stays 0 and the other outputs hold their last values.
- R3: When several unmasked requests are present together, the winner follows this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R4: A normal interrupt is ignored while status_i bit 7 is 1. A fast interrupt is ignored while status_i bit 6 is 1. A masked request does not block a lower-priority request.
- R5: Reset entry gives mode 5'b10011, sets bits 7 and 6, clears bit 5, targets VEC_BASE+0x00 and links to the current PC.
- R6: Fast interrupt entry gives mode 5'b10001, sets bits 7 and 6, targets VEC_BASE+0x1C and links to PC-4.
- R7: Normal interrupt entry gives mode 5'b10010, sets bit 7, leaves bit 6 unchanged, targets VEC_BASE+0x18 and links to PC-4.
- R8: Software interrupt entry gives mode 5'b10011, sets bit 7, leaves bit 6 unchanged, targets VEC_BASE+0x08 and links to PC+4.
- R9: Undefined instruction entry gives mode 5'b11011, sets bit 7, targets VEC_BASE+0x04 and links to PC+4.
- R10: Both aborts give mode 5'b10111 and set bit 7. A prefetch abort targets VEC_BASE+0x0C and links to PC+4. A data abort targets VEC_BASE+0x10 and links to PC+8.
- R11: On every entry, saved_o equals the sampled status_i and bit 5 of status_o is cleared. Status bits other than [7:0], and bit 6 where the rule for that exception leaves it alone, pass through unchanged.
- R12: Link arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | Core reset request |
| fiq_i | input | 1 | Fast interrupt request (level) |
| irq_i | input | 1 | Normal interrupt request (level) |
| swi_i | input | 1 | Software-interrupt instruction strobe |
| undef_i | input | 1 | Undefined-instruction strobe |
| pabt_i | input | 1 | Prefetch abort strobe |
| dabt_i | input | 1 | Data abort strobe |
| pc_i | input | PC_W | Current or faulting instruction address |
| status_i | input | ST_W | Current status word |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| target_o | output | PC_W | Handler address |
| status_o | output | ST_W | Status word for the entered mode |
| link_o | output | PC_W | Banked link register value |
| saved_o | output | ST_W | Banked saved-status value |

## Verification
The bench builds the block with its defaults: PC_W=32, ST_W=32 and VEC_BASE=0. With full 32-bit addresses, PC-4 from address zero and PC+8 from the top of the address space are both reachable, so link wrap-around can be checked directly. A full 32-bit status word lets random upper bits show that they are preserved. Directed cases cover the following:
- each exception kind on its own;
- each pairwise priority conflict;
- a masked interrupt alone, and a masked interrupt beside a lower-priority request.

After the directed cases, thousands of random request mixes are compared against a model built from the priority and masking rules.

// File: rtl/exc_pkg.sv
// Shared definitions for the exception entry sequencer.
// Assumes a status word whose low byte carries mode, T, F and I at fixed bits.
package exc_pkg;

    // Kind codes; numeric order equals priority order (1 = highest).
    typedef enum logic [2:0] {
        EK_NONE  = 3'd0,
        EK_RESET = 3'd1,
        EK_DABT  = 3'd2,
        EK_FIQ   = 3'd3,
        EK_IRQ   = 3'd4,
        EK_PABT  = 3'd5,
        EK_UNDEF = 3'd6,
        EK_SWI   = 3'd7
    } exc_kind_e;

    localparam int NUM_KINDS = 7;

    // Status word field positions decoded by the rest of the core.
    localparam int MODE_W   = 5;
    localparam int T_BIT    = 5;
    localparam int F_BIT    = 6;
    localparam int I_BIT    = 7;

    // Mode codes.
    localparam logic [MODE_W-1:0] MODE_FAST = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_INTR = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SUPV = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABRT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UNDF = 5'b11011;

    // Link adjustment selector.
    typedef enum logic [1:0] {
        LNK_ZERO  = 2'd0,
        LNK_MINUS4 = 2'd1,
        LNK_PLUS4 = 2'd2,
        LNK_PLUS8 = 2'd3
    } link_adj_e;

    // Per-kind entry attributes.
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [4:0]        vec_off;
        logic              set_f;
        link_adj_e         link_adj;
    } entry_attr_t;

endpackage

// File: rtl/exc_pend_arb.sv
// Masks the two interrupt classes with the status disable bits and picks one
// pending exception by fixed priority (reset highest, software interrupt
// lowest). Purely combinational; assumes strobes are valid for the sampled cycle.
module exc_pend_arb
    import exc_pkg::*;
(
    input  logic      rst_req_i,
    input  logic      dabt_i,
    input  logic      fiq_i,
    input  logic      irq_i,
    input  logic      pabt_i,
    input  logic      undef_i,
    input  logic      swi_i,
    input  logic      i_mask_i,
    input  logic      f_mask_i,
    output exc_kind_e kind_o
);

    logic [NUM_KINDS:1] pend;
    logic [NUM_KINDS:1] blocked;
    logic [NUM_KINDS:1] grant;

    // Build the pending vector in priority order, interrupts gated by masks.
    always_comb begin
        pend[1] = rst_req_i;
        pend[2] = dabt_i;
        pend[3] = fiq_i & ~f_mask_i;
        pend[4] = irq_i & ~i_mask_i;
        pend[5] = pabt_i;
        pend[6] = undef_i;
        pend[7] = swi_i;
    end

    // Prefix chain: a slot is granted only when no higher slot is pending.
    for (genvar k = 1; k <= NUM_KINDS; k++) begin : g_prio
        if (k == 1) begin : g_top
            assign blocked[k] = 1'b0;
        end else begin : g_rest
            assign blocked[k] = blocked[k-1] | pend[k-1];
        end
        assign grant[k] = pend[k] & ~blocked[k];
    end

    // Encode the one-hot grant into a kind code.
    always_comb begin
        kind_o = EK_NONE;
        for (int k = 1; k <= NUM_KINDS; k++) begin
            if (grant[k]) kind_o = exc_kind_e'(k[2:0]);
        end
    end

endmodule

// File: rtl/exc_entry_calc.sv
// Turns a winning exception kind into handler address, new status, link value
// and saved status. Combinational; assumes pc_i is the faulting instruction
// address for synchronous kinds and the current PC for interrupts and reset.
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              ST_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input  exc_kind_e         kind_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [ST_W-1:0]   status_i,
    output logic              take_o,
    output logic [PC_W-1:0]   target_o,
    output logic [ST_W-1:0]   status_o,
    output logic [PC_W-1:0]   link_o,
    output logic [ST_W-1:0]   saved_o
);

    localparam logic [PC_W-1:0] ADJ_M4 = ~PC_W'(3);
    localparam logic [PC_W-1:0] ADJ_P4 = PC_W'(4);
    localparam logic [PC_W-1:0] ADJ_P8 = PC_W'(8);

    entry_attr_t     attr;
    logic [PC_W-1:0] adj;

    // Look up mode, vector slot, F behaviour and link offset for the kind.
    always_comb begin
        attr = '{mode: MODE_SUPV, vec_off: 5'h00, set_f: 1'b1, link_adj: LNK_ZERO};
        unique case (kind_i)
            EK_RESET: attr = '{mode: MODE_SUPV, vec_off: 5'h00, set_f: 1'b1, link_adj: LNK_ZERO};
            EK_UNDEF: attr = '{mode: MODE_UNDF, vec_off: 5'h04, set_f: 1'b0, link_adj: LNK_PLUS4};
            EK_SWI:   attr = '{mode: MODE_SUPV, vec_off: 5'h08, set_f: 1'b0, link_adj: LNK_PLUS4};
            EK_PABT:  attr = '{mode: MODE_ABRT, vec_off: 5'h0C, set_f: 1'b0, link_adj: LNK_PLUS4};
            EK_DABT:  attr = '{mode: MODE_ABRT, vec_off: 5'h10, set_f: 1'b0, link_adj: LNK_PLUS8};
            EK_IRQ:   attr = '{mode: MODE_INTR, vec_off: 5'h18, set_f: 1'b0, link_adj: LNK_MINUS4};
            EK_FIQ:   attr = '{mode: MODE_FAST, vec_off: 5'h1C, set_f: 1'b1, link_adj: LNK_MINUS4};
            default:  attr = '{mode: MODE_SUPV, vec_off: 5'h00, set_f: 1'b1, link_adj: LNK_ZERO};
        endcase
    end

    // Select the link offset as a PC-width two's-complement addend.
    always_comb begin
        unique case (attr.link_adj)
            LNK_MINUS4: adj = ADJ_M4;
            LNK_PLUS4:  adj = ADJ_P4;
            LNK_PLUS8:  adj = ADJ_P8;
            default:    adj = '0;
        endcase
    end

    // Build the entered-mode status word from the incoming one.
    always_comb begin
        status_o                 = status_i;
        status_o[MODE_W-1:0]     = attr.mode;
        status_o[T_BIT]          = 1'b0;
        status_o[I_BIT]          = 1'b1;
        if (attr.set_f) status_o[F_BIT] = 1'b1;
    end

    assign take_o   = (kind_i != EK_NONE);
    assign target_o = VEC_BASE + PC_W'(attr.vec_off);
    assign link_o   = pc_i + adj;
    assign saved_o  = status_i;

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. Samples requests, PC and status each cycle,
// arbitrates, and registers the entry results so they appear one clock later
// with a single-cycle redirect pulse. Outputs hold between entries.
// Assumes ST_W >= 8 and PC_W >= 5.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              ST_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req_i,
    input  logic            fiq_i,
    input  logic            irq_i,
    input  logic            swi_i,
    input  logic            undef_i,
    input  logic            pabt_i,
    input  logic            dabt_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [ST_W-1:0] status_i,
    output logic            redirect_o,
    output logic [PC_W-1:0] target_o,
    output logic [ST_W-1:0] status_o,
    output logic [PC_W-1:0] link_o,
    output logic [ST_W-1:0] saved_o
);

    exc_kind_e       kind;
    logic            take;
    logic [PC_W-1:0] nxt_target;
    logic [ST_W-1:0] nxt_status;
    logic [PC_W-1:0] nxt_link;
    logic [ST_W-1:0] nxt_saved;

    exc_pend_arb u_arb (
        .rst_req_i (rst_req_i),
        .dabt_i    (dabt_i),
        .fiq_i     (fiq_i),
        .irq_i     (irq_i),
        .pabt_i    (pabt_i),
        .undef_i   (undef_i),
        .swi_i     (swi_i),
        .i_mask_i  (status_i[I_BIT]),
        .f_mask_i  (status_i[F_BIT]),
        .kind_o    (kind)
    );

    exc_entry_calc #(
        .PC_W     (PC_W),
        .ST_W     (ST_W),
        .VEC_BASE (VEC_BASE)
    ) u_calc (
        .kind_i   (kind),
        .pc_i     (pc_i),
        .status_i (status_i),
        .take_o   (take),
        .target_o (nxt_target),
        .status_o (nxt_status),
        .link_o   (nxt_link),
        .saved_o  (nxt_saved)
    );

    // Register the redirect pulse and capture entry results on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o <= 1'b0;
            target_o   <= '0;
            status_o   <= '0;
            link_o     <= '0;
            saved_o    <= '0;
        end else begin
            redirect_o <= take;
            if (take) begin
                target_o <= nxt_target;
                status_o <= nxt_status;
                link_o   <= nxt_link;
                saved_o  <= nxt_saved;
            end
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for exc_entry_seq, attached by bind below. Uses a one-bit
// history flag so no $past reaches before the first cycle out of reset.
module exc_entry_chk #(
    parameter int              PC_W     = 32,
    parameter int              ST_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req_i,
    input logic            fiq_i,
    input logic            irq_i,
    input logic            swi_i,
    input logic            undef_i,
    input logic            pabt_i,
    input logic            dabt_i,
    input logic [PC_W-1:0] pc_i,
    input logic [ST_W-1:0] status_i,
    input logic            redirect_o,
    input logic [PC_W-1:0] target_o,
    input logic [ST_W-1:0] status_o,
    input logic [PC_W-1:0] link_o,
    input logic [ST_W-1:0] saved_o
);

    logic seen;

    // Marks that at least one cycle out of reset has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(!rst_req_i && !fiq_i && !irq_i && !swi_i && !undef_i && !pabt_i && !dabt_i)
        |-> !redirect_o);

    p_reset_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_req_i) |-> redirect_o && target_o == VEC_BASE &&
        status_o[4:0] == 5'b10011 && status_o[7] && status_o[6] && !status_o[5]);

    p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(irq_i && status_i[7] && !rst_req_i && !fiq_i && !swi_i &&
                      !undef_i && !pabt_i && !dabt_i) |-> !redirect_o);

    p_fiq_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o && status_o[4:0] == 5'b10001 |-> status_o[7] && status_o[6]);

    p_irq_keep_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen && redirect_o && status_o[4:0] == 5'b10010 |->
        status_o[6] == $past(status_i[6]) && link_o == $past(pc_i) - PC_W'(4));

    p_saved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seen && redirect_o |-> saved_o == $past(status_i) && !status_o[5]);

    p_dabt_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(dabt_i && !rst_req_i) |-> redirect_o &&
        status_o[4:0] == 5'b10111 && target_o == VEC_BASE + PC_W'(16));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .PC_W     (PC_W),
    .ST_W     (ST_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req_i  (rst_req_i),
    .fiq_i      (fiq_i),
    .irq_i      (irq_i),
    .swi_i      (swi_i),
    .undef_i    (undef_i),
    .pabt_i     (pabt_i),
    .dabt_i     (dabt_i),
    .pc_i       (pc_i),
    .status_i   (status_i),
    .redirect_o (redirect_o),
    .target_o   (target_o),
    .status_o   (status_o),
    .link_o     (link_o),
    .saved_o    (saved_o)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

    localparam int PC_W = 32;
    localparam int ST_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            rst_req_i, fiq_i, irq_i, swi_i, undef_i, pabt_i, dabt_i;
    logic [PC_W-1:0] pc_i;
    logic [ST_W-1:0] status_i;
    logic            redirect_o;
    logic [PC_W-1:0] target_o, link_o;
    logic [ST_W-1:0] status_o, saved_o;

    int checks = 0;
    int fails  = 0;

    logic            e_red;
    logic [PC_W-1:0] e_tgt, e_lnk;
    logic [ST_W-1:0] e_st, e_sav;

    always #4 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .fiq_i(fiq_i),
        .irq_i(irq_i), .swi_i(swi_i), .undef_i(undef_i), .pabt_i(pabt_i),
        .dabt_i(dabt_i), .pc_i(pc_i), .status_i(status_i),
        .redirect_o(redirect_o), .target_o(target_o), .status_o(status_o),
        .link_o(link_o), .saved_o(saved_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "redirect", 32'(redirect_o), 32'(e_red));
        chk(tag, "target",   target_o, e_tgt);
        chk(tag, "status",   status_o, e_st);
        chk(tag, "link",     link_o,   e_lnk);
        chk(tag, "saved",    saved_o,  e_sav);
    endtask

    // Reference model from the requirements: update expected outputs.
    task automatic model();
        logic [4:0]      md;
        logic [4:0]      vo;
        logic            sf;
        logic [PC_W-1:0] lk;
        logic            hit;
        hit = 1'b1; sf = 1'b0; md = 5'b0; vo = 5'h0; lk = pc_i;
        if (rst_req_i)                     begin md = 5'b10011; vo = 5'h00; sf = 1'b1; lk = pc_i; end
        else if (dabt_i)                   begin md = 5'b10111; vo = 5'h10; lk = pc_i + 8; end
        else if (fiq_i && !status_i[6])    begin md = 5'b10001; vo = 5'h1C; sf = 1'b1; lk = pc_i - 4; end
        else if (irq_i && !status_i[7])    begin md = 5'b10010; vo = 5'h18; lk = pc_i - 4; end
        else if (pabt_i)                   begin md = 5'b10111; vo = 5'h0C; lk = pc_i + 4; end
        else if (undef_i)                  begin md = 5'b11011; vo = 5'h04; lk = pc_i + 4; end
        else if (swi_i)                    begin md = 5'b10011; vo = 5'h08; lk = pc_i + 4; end
        else hit = 1'b0;
        e_red = hit;
        if (hit) begin
            e_tgt = 32'(vo);
            e_lnk = lk;
            e_sav = status_i;
            e_st  = status_i;
            e_st[4:0] = md;
            e_st[5] = 1'b0;
            e_st[7] = 1'b1;
            if (sf) e_st[6] = 1'b1;
        end
    endtask

    // req bits: {reset, dabt, fiq, irq, pabt, undef, swi}; drive, model, check.
    task automatic step(input string tag, input logic [6:0] req,
                        input logic [PC_W-1:0] pc, input logic [ST_W-1:0] st);
        {rst_req_i, dabt_i, fiq_i, irq_i, pabt_i, undef_i, swi_i} = req;
        pc_i = pc;
        status_i = st;
        model();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        {rst_req_i, dabt_i, fiq_i, irq_i, pabt_i, undef_i, swi_i} = 7'h7F;
        pc_i = 32'h1234_5678;
        status_i = 32'h0;
        e_red = 0; e_tgt = 0; e_st = 0; e_lnk = 0; e_sav = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        {rst_req_i, dabt_i, fiq_i, irq_i, pabt_i, undef_i, swi_i} = 7'h0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // Each kind alone (R5..R10), status with random upper bits (R11).
        step("R5",  7'b1000000, 32'h0000_1000, 32'hA5A5_0010);
        step("R2",  7'b0000000, 32'h0000_2000, 32'h0000_0010);
        step("R10", 7'b0100000, 32'h0000_3000, 32'h5A00_0010);
        step("R6",  7'b0010000, 32'h0000_4000, 32'h0F00_0030);
        step("R7",  7'b0001000, 32'h0000_5000, 32'h00F0_0010);
        step("R7",  7'b0001000, 32'h0000_5100, 32'h00F0_0050);
        step("R10", 7'b0000100, 32'h0000_6000, 32'h1234_0010);
        step("R9",  7'b0000010, 32'h0000_7000, 32'h8000_0030);
        step("R8",  7'b0000001, 32'h0000_8000, 32'h0000_0050);
        step("R11", 7'b0000001, 32'h0000_8004, 32'hFFFF_FF10);

        // Masking (R4): masked alone leaves outputs held and no pulse.
        step("R4",  7'b0001000, 32'h0000_9000, 32'h0000_0090);
        step("R4",  7'b0010000, 32'h0000_9100, 32'h0000_0050);
        step("R4",  7'b0011000, 32'h0000_9200, 32'h0000_0050);
        step("R4",  7'b0001100, 32'h0000_9300, 32'h0000_0090);
        step("R4",  7'b0011000, 32'h0000_9400, 32'h0000_00D0);

        // Priority pairs (R3).
        step("R3",  7'b1111111, 32'h0000_A000, 32'h0000_0010);
        step("R3",  7'b0111111, 32'h0000_A100, 32'h0000_0010);
        step("R3",  7'b0011111, 32'h0000_A200, 32'h0000_0010);
        step("R3",  7'b0001111, 32'h0000_A300, 32'h0000_0010);
        step("R3",  7'b0000111, 32'h0000_A400, 32'h0000_0010);
        step("R3",  7'b0000011, 32'h0000_A500, 32'h0000_0010);

        // Wrap-around (R12).
        step("R12", 7'b0001000, 32'h0000_0000, 32'h0000_0010);
        step("R12", 7'b0100000, 32'hFFFF_FFFC, 32'h0000_0010);
        step("R12", 7'b0000001, 32'hFFFF_FFFE, 32'h0000_0010);

        // Back-to-back pulse shape (R2).
        step("R2",  7'b0000001, 32'h0000_B000, 32'h0000_0010);
        step("R2",  7'b0000000, 32'h0000_B004, 32'h0000_0010);

        // Random mixes (R3, R4, R11).
        for (int n = 0; n < 4000; n++) begin
            logic [6:0] rq;
            for (int b = 0; b < 7; b++) rq[b] = (($urandom % 6) == 0);
            if (($urandom % 4) != 0) rq[6] = 1'b0;
            step("R3", rq, $urandom, $urandom);
        end

        step("R2", 7'b0000000, 32'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule